// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Master

This block drives a single slave over three wires: an enable, a serial clock and one data line shared by both directions. Each transaction is a fixed two-byte frame. A command byte always goes out first. After it, the port either sends one data byte to the slave or takes one data byte back from it. The port is always the bus master. Inside the chip the shared data line appears as an output value, an output enable and an input value, which are combined at the pad.

The host starts a frame with a valid/ready request that carries the command byte, the direction and the byte to write. `req_ready` is high only while the port is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` may stay high for as long as needed. While a frame runs, the port offers no ready, so a request made then is never taken. There is no back-pressure on the result side. `done` pulses for one cycle, and `rd_data` keeps the received byte until the next read completes.

The configuration inputs set the divide ratio, the idle level of the clock, the active level of the enable and the bit order. The port uses these inputs live while it is idle and latches them when it accepts a request.

Top module: `ssm_port`

## Requirements
- R1: After reset the port is idle. `busy` and `done` are low, `req_ready` is high and `sd_oe` is low.
- R2: An accepted request produces exactly one frame of 16 clock pulses with the enable held active. The first 8 bits carry the command byte, and `sd_oe` is high for all of them.
- R3: In a write frame (`req_rd`=0), bits 8 to 15 carry the write byte and `sd_oe` stays high through bit 15.
- R4: In a read frame (`req_rd`=1), `sd_oe` is low for bits 8 to 15. The 8 bits sampled from `sd_in` are loaded into `rd_data` in the cycle in which `done` is high. A write frame leaves `rd_data` unchanged.
- R5: The idle level of `sd_clk` equals `cfg_cpol`. Each bit spends its first half at the idle level and its second half at the opposite level, so its leading edge leaves the idle level.
- R6: The active level of `sd_en` equals `cfg_epol`. Outside a frame `sd_en` is the inverse of `cfg_epol`, and inside a frame it does not change.
- R7: With `cfg_lsb_first`=1 each byte is sent and received least significant bit first. With `cfg_lsb_first`=0 it is most significant bit first.
- R8: Each half of a bit lasts H = 2^`cfg_div` system clocks, so a bit lasts 2^(`cfg_div`+1) clocks. `cfg_div` values 0 to 7 give divide ratios of 2 to 256.
- R9: The enable turns active H clocks before the first leading edge. It turns inactive H clocks after the last trailing edge. `done` is high for exactly one cycle, namely the first cycle with the enable inactive.
- R10: While a frame runs, `req_ready` is low and a request has no effect. No extra frame starts and the current frame's bits are unchanged.
- R11: Changes to `cfg_div` or `cfg_lsb_first` made during a frame do not affect that frame.
- R12: `sd_in` is sampled on the leading clock edge of each read bit. `sd_out` changes only together with a trailing edge or at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Port idle, request can be taken |
| req_cmd | input | DW | Command byte |
| req_rd | input | 1 | 1 = read data byte, 0 = write data byte |
| req_wdata | input | DW | Byte to write |
| cfg_div | input | SEL_W | Half-bit length exponent, H = 2^cfg_div |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_epol | input | 1 | Active level of the enable |
| cfg_lsb_first | input | 1 | Bit order select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | DW | Last byte read |
| sd_en | output | 1 | Slave enable |
| sd_clk | output | 1 | Serial clock |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_in | input | 1 | Data line input value |

## Verification
Everything is timed from the clock edge that accepts a request. The enable and `busy` change one cycle after that edge. The first leading edge follows H cycles later, and each later edge follows H cycles after the one before it. The last trailing edge falls at 32H, and the enable turns off and `done` rises together at 33H, with `rd_data` already updated. The bench samples the pins on falling clock edges and stamps each event with a cycle number. It then compares the intervals between events against multiples of H instead of waiting for fixed delays. A model slave changes `sd_in` only just after a leading edge, so a port that sampled on the wrong edge would read back the wrong byte.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } ssm_state_e;

  typedef struct packed {
    logic cpol;
    logic epol;
    logic lsb_first;
    logic rd;
  } ssm_mode_t;
endpackage

// File: rtl/ssm_clkdiv.sv
module ssm_clkdiv #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             half_end
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // limit is 2^sel - 1: a run of sel ones
  always_comb lim = ~({CNT_W{1'b1}} << sel);
  always_comb half_end = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || half_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          sample,
  input  logic          sin,
  input  logic          shift,
  input  logic          lsb_first,
  output logic          sout,
  output logic [DW-1:0] q
);
  logic rx_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)      rx_bit <= 1'b0;
    else if (sample) rx_bit <= sin;
  end

  // one register: outgoing bit leaves one end, captured bit enters the other
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= lsb_first ? {rx_bit, q[DW-1:1]} : {q[DW-2:0], rx_bit};
  end

  always_comb sout = lsb_first ? q[0] : q[DW-1];
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int DW = 8,
  localparam int NBITS = 2 * DW,
  localparam int BC_W = $clog2(NBITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            half_end,
  input  logic            rd,
  output ssm_state_e      state,
  output logic            phase,
  output logic [BC_W-1:0] bitcnt,
  output logic            lead,
  output logic            trail,
  output logic            load_data,
  output logic            finish,
  output logic            drive,
  output logic            done
);
  logic last_bit;

  always_comb begin
    lead      = (state == ST_SHIFT) && half_end && !phase;
    trail     = (state == ST_SHIFT) && half_end && phase;
    last_bit  = (bitcnt == BC_W'(NBITS - 1));
    load_data = trail && (bitcnt == BC_W'(DW - 1)) && !rd;
    finish    = (state == ST_TAIL) && half_end;
    drive     = (state == ST_SHIFT) && (!rd || (bitcnt < BC_W'(DW)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      bitcnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_SHIFT;
            phase  <= 1'b0;
            bitcnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (lead) phase <= 1'b1;
          if (trail) begin
            phase <= 1'b0;
            if (last_bit) state <= ST_TAIL;
            else          bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (half_end) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssm_port.sv
module ssm_port
  import ssm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 3,
  localparam int BC_W = $clog2(2 * DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [DW-1:0]    req_cmd,
  input  logic             req_rd,
  input  logic [DW-1:0]    req_wdata,
  input  logic [SEL_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_epol,
  input  logic             cfg_lsb_first,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             sd_en,
  output logic             sd_clk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in
);
  ssm_state_e       state;
  ssm_mode_t        mode_q;
  logic [SEL_W-1:0] div_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    sh_q;
  logic [BC_W-1:0]  bitcnt;
  logic             phase, lead, trail, load_data, finish, drive;
  logic             half_end, accept, sout;

  always_comb begin
    busy      = (state != ST_IDLE);
    req_ready = !busy;
    accept    = req_valid && req_ready;
  end

  // frame settings are frozen at the accepting edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      div_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mode_q  <= '{cpol: cfg_cpol, epol: cfg_epol, lsb_first: cfg_lsb_first, rd: req_rd};
      div_q   <= cfg_div;
      wdata_q <= req_wdata;
    end
  end

  ssm_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .half_end (half_end),
    .rd       (mode_q.rd),
    .state    (state),
    .phase    (phase),
    .bitcnt   (bitcnt),
    .lead     (lead),
    .trail    (trail),
    .load_data(load_data),
    .finish   (finish),
    .drive    (drive),
    .done     (done)
  );

  ssm_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .sel     (div_q),
    .half_end(half_end)
  );

  ssm_shifter #(.DW(DW)) u_sh (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept || load_data),
    .load_val (accept ? req_cmd : wdata_q),
    .sample   (lead && !drive),
    .sin      (sd_in),
    .shift    (trail),
    .lsb_first(mode_q.lsb_first),
    .sout     (sout),
    .q        (sh_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_data <= '0;
    else if (finish && mode_q.rd) rd_data <= sh_q;
  end

  always_comb begin
    sd_en  = busy ? mode_q.epol : ~cfg_epol;
    sd_clk = busy ? (mode_q.cpol ^ ((state == ST_SHIFT) && phase)) : cfg_cpol;
    sd_oe  = drive;
    sd_out = drive && sout;
  end
endmodule

// File: rtl/ssm_port_chk.sv
module ssm_port_chk #(
  parameter int DW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic cfg_cpol,
  input logic cfg_epol,
  input logic busy,
  input logic done,
  input logic sd_en,
  input logic sd_clk,
  input logic sd_oe
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && sd_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_idle_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_clk == cfg_cpol && !sd_oe));

  p_idle_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sd_en == !cfg_epol));

  p_en_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sd_en));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !req_ready);
endmodule

bind ssm_port ssm_port_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .cfg_cpol (cfg_cpol),
  .cfg_epol (cfg_epol),
  .busy     (busy),
  .done     (done),
  .sd_en    (sd_en),
  .sd_clk   (sd_clk),
  .sd_oe    (sd_oe)
);

// File: tb/tb_ssm_port.sv
module tb_ssm_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_cmd = '0;
  logic       req_rd = 1'b0;
  logic [7:0] req_wdata = '0;
  logic [2:0] cfg_div = '0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_epol = 1'b1;
  logic       cfg_lsb_first = 1'b0;
  logic       busy, done, sd_en, sd_clk, sd_out, sd_oe;
  logic [7:0] rd_data;
  logic       sd_in = 1'b0;

  always #10 clk = ~clk;

  ssm_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_rd(req_rd), .req_wdata(req_wdata),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_epol(cfg_epol),
    .cfg_lsb_first(cfg_lsb_first), .busy(busy), .done(done), .rd_data(rd_data),
    .sd_en(sd_en), .sd_clk(sd_clk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic obit(input logic [7:0] b, input int j, input logic lsb);
    return lsb ? b[j] : b[7-j];
  endfunction

  // slave model and pin monitor, sampled on falling edges
  logic m_cpol = 1'b0, m_epol = 1'b1, m_lsb = 1'b0, m_rd = 1'b0;
  logic [7:0] m_sb = '0;
  logic en_prev = 1'b0, clk_prev = 1'b0, mcp_prev = 1'b0, en_now;
  int cyc = 0, frames = 0, nbits = 0, en_start = 0, first_lead = 0;
  int last_trail = 0, en_end = 0, done_cnt = 0, done_cyc = 0, idle_glitch = 0;
  logic cap [16];
  logic oec [16];

  always @(negedge clk) begin
    cyc++;
    en_now = (sd_en === m_epol);
    if (rst_n) begin
      if (en_now && !en_prev) begin
        frames++; en_start = cyc; nbits = 0; sd_in = 1'b0;
      end
      if (en_now && en_prev && sd_clk !== clk_prev) begin
        if (sd_clk !== m_cpol) begin
          if (nbits == 0) first_lead = cyc;
          if (nbits < 16) begin cap[nbits] = sd_out; oec[nbits] = sd_oe; end
          nbits++;
          sd_in = (m_rd && nbits >= 8 && nbits < 16) ? obit(m_sb, nbits - 8, m_lsb) : 1'b0;
        end else begin
          last_trail = cyc;
        end
      end
      if (!en_now && en_prev) en_end = cyc;
      if (!en_now && !en_prev && sd_clk !== clk_prev && m_cpol === mcp_prev) idle_glitch++;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
    en_prev = en_now; clk_prev = sd_clk; mcp_prev = m_cpol;
  end

  // disturb: 0 none, 1 request while busy, 2 config change mid-frame
  task automatic do_frame(input logic [7:0] cmd, input logic rd, input logic [7:0] wd,
                          input logic [7:0] sb, input int div, input logic cp,
                          input logic ep, input logic lsb, input int disturb);
    int h, f0, errc, errd, erro;
    logic [7:0] rd_before;
    h = 1 << div;
    @(posedge clk); #1;
    cfg_div = 3'(div); cfg_cpol = cp; cfg_epol = ep; cfg_lsb_first = lsb;
    m_cpol = cp; m_epol = ep; m_lsb = lsb; m_sb = sb; m_rd = rd;
    repeat (3) @(posedge clk); #1;
    rd_before = rd_data; f0 = frames; done_cnt = 0; idle_glitch = 0;
    req_cmd = cmd; req_rd = rd; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (disturb == 1) begin
      repeat (5) @(posedge clk); #1;
      chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
      req_cmd = 8'hFF; req_rd = ~rd; req_wdata = ~wd; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    if (disturb == 2) begin
      repeat (5) @(posedge clk); #1;
      cfg_div = 3'(div) ^ 3'd5; cfg_lsb_first = ~lsb;
    end
    while (done_cnt == 0) @(posedge clk);
    repeat (40) @(posedge clk); #1;
    cfg_div = 3'(div); cfg_lsb_first = lsb;
    chk(frames - f0 == 1, "R2/R10", "frames started", frames - f0, 1);
    chk(nbits == 16, "R2", "clock pulses", nbits, 16);
    errc = 0; errd = 0; erro = 0;
    for (int j = 0; j < 8; j++) begin
      if (cap[j] !== obit(cmd, j, lsb)) errc++;
      if (oec[j] !== 1'b1) erro++;
      if (oec[j+8] !== !rd) erro++;
      if (!rd && cap[j+8] !== obit(wd, j, lsb)) errd++;
    end
    chk(errc == 0, "R2/R7/R12", "command bit errors", errc, 0);
    chk(erro == 0, rd ? "R4" : "R3", "output enable errors", erro, 0);
    if (!rd) begin
      chk(errd == 0, "R3/R7", "write bit errors", errd, 0);
      chk(rd_data == rd_before, "R4", "rd_data after write", int'(rd_data), int'(rd_before));
    end else begin
      chk(rd_data == sb, "R4/R7/R12", "read byte", int'(rd_data), int'(sb));
    end
    chk(first_lead - en_start == h, "R9", "enable lead", first_lead - en_start, h);
    chk(last_trail - first_lead == 31 * h, "R8/R11", "edge span", last_trail - first_lead, 31 * h);
    chk(en_end - last_trail == h, "R9", "enable trail", en_end - last_trail, h);
    chk(done_cnt == 1 && done_cyc == en_end, "R9", "done pulse", done_cyc - en_end, 0);
    chk(idle_glitch == 0, "R5", "idle clock toggles", idle_glitch, 0);
    chk(sd_clk == cp && sd_en == ~ep && !busy, "R5/R6", "idle levels",
        int'({sd_clk, sd_en, busy}), int'({cp, ~ep, 1'b0}));
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk); #1;
    chk(!busy && !done && req_ready && !sd_oe, "R1", "in reset",
        int'({busy, done, req_ready, sd_oe}), 2);
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk(!busy && !done && req_ready && !sd_oe, "R1", "after reset",
        int'({busy, done, req_ready, sd_oe}), 2);
    chk(sd_en == 1'b0 && sd_clk == 1'b0, "R1/R6", "idle pins", int'({sd_en, sd_clk}), 0);
  endtask

  task automatic t_write_basic();   do_frame(8'hA5, 1'b0, 8'h3C, 8'h00, 0, 1'b0, 1'b1, 1'b0, 0); endtask
  task automatic t_read_lsb();      do_frame(8'h81, 1'b1, 8'h00, 8'hC6, 2, 1'b1, 1'b0, 1'b1, 0); endtask
  task automatic t_write_slow();    do_frame(8'h5A, 1'b0, 8'hF0, 8'h00, 7, 1'b0, 1'b0, 1'b1, 0); endtask
  task automatic t_read_msb();      do_frame(8'h0F, 1'b1, 8'h00, 8'h96, 1, 1'b1, 1'b1, 1'b0, 0); endtask
  task automatic t_busy_ignore();   do_frame(8'h33, 1'b0, 8'hCC, 8'h00, 3, 1'b0, 1'b1, 1'b0, 1); endtask
  task automatic t_cfg_midframe();  do_frame(8'h47, 1'b1, 8'h00, 8'h2B, 1, 1'b0, 1'b1, 1'b0, 2); endtask

  initial begin
    t_reset();
    t_write_basic();
    t_read_lsb();
    t_write_slow();
    t_read_msb();
    t_busy_ignore();
    t_cfg_midframe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule